// File: doc/BRIEF.md
# Cache Line-Fill Read Master

This block is the read-request side of a data-cache unit sitting on a 64-bit local bus. The load pipeline hands it one request at a time through a valid/ready port. Each request is either a full cache-line read of four doublewords or a single-word read. The block raises a bus request with address, byte enables and a size flag, and holds it until the bus acknowledges the address. It then gathers the returned doubleword beats into a four-slot fill buffer. Each beat lands in the slot named by its word address.

When all beats are in, the block offers the doubleword the load asked for on a valid/ready response port. Bytes whose enable is clear read as zero. The response holds valid and keeps its data stable until the consumer raises ready; no handshake completes while ready is low. After a cacheable line has been handed over, the block spends a fixed number of cycles presenting the whole line on the cache-write port, and it accepts no new load during that time. Data from a non-cacheable read stays in the fill buffer and never reaches the cache-write port.

The load port accepts nothing from acceptance until the block is idle again, so every read, word or line, is strictly serialized. The busy output tells the load pipeline that a request is outstanding.

Top module: `linefill_rd_master`

## Requirements
- R1: While reset is held, and in the first cycle after it, bus_req, rsp_valid and cw_wr are 0, busy is 0 and ld_ready is 1.
- R2: Once bus_req is high it stays high, with bus_addr, bus_be and bus_size_line unchanged, until bus_addrack is sampled high. bus_rnw is 1 whenever bus_req is high.
- R3: A line request drives bus_size_line=1, bus_be=8'hFF and bus_addr with bits [4:0] cleared. A word request drives bus_size_line=0 and passes ld_addr and ld_be through unchanged.
- R4: bus_req rises in the cycle after a load is accepted. An address acknowledge in that same cycle drops bus_req in the next cycle.
- R5: A beat with bus_rdack=1 is stored in fill slot bus_rdwdaddr[2:1]. A line completes correctly whatever order its four beats return in.
- R6: rsp_data is fill slot addr[4:3] of the request. Byte i (bits 8i+7..8i) is that slot's byte when enable bit i is set, and zero when it is clear.
- R7: From the cycle after a load is accepted until the block returns to idle, ld_ready is 0 and busy is 1. A load offered in that time is ignored and starts no bus request.
- R8: After the response to a cacheable line is taken, cw_wr is high for exactly 3 consecutive cycles. cw_commit is high only in the last of them. cw_line carries slot k at bits [64k+63:64k], and cw_addr holds the line address. ld_ready is 0 throughout.
- R9: A non-cacheable read, line or word, never asserts cw_wr.
- R10: rsp_valid rises in the cycle after the final beat. It then stays high, with rsp_data stable, until rsp_ready is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request offered |
| ld_ready | output | 1 | Block can accept a load |
| ld_addr | input | 32 | Load byte address |
| ld_line | input | 1 | 1 = line read, 0 = single-word read |
| ld_cacheable | input | 1 | Request may be written into the cache |
| ld_be | input | 8 | Byte enables for the requested doubleword |
| bus_req | output | 1 | Bus read request |
| bus_rnw | output | 1 | Read/not-write, 1 for every request here |
| bus_addr | output | 32 | Request address |
| bus_be | output | 8 | Request byte enables |
| bus_size_line | output | 1 | 1 = four-beat line transfer |
| bus_addrack | input | 1 | Address acknowledge |
| bus_rdack | input | 1 | Read data beat valid |
| bus_rddata | input | 64 | Read data beat |
| bus_rdwdaddr | input | 3 | Word address of the beat |
| rsp_valid | output | 1 | Response data valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 64 | Byte-selected doubleword |
| busy | output | 1 | Request outstanding |
| cw_wr | output | 1 | Cache-write transfer in progress |
| cw_commit | output | 1 | Last cycle of the cache-write transfer |
| cw_addr | output | 32 | Line address for the cache write |
| cw_line | output | 256 | Full line from the fill buffer |

## Verification
A miscounted beat counter shows at the ports within one beat: rsp_valid comes early or late relative to the last bus_rdack, or cw_line holds a stale slot. A wrong slot index shows the first time beats return out of order, as a displaced doubleword in rsp_data or cw_line. A control state that leaves its transfer phase too early or too late shows in the same handshake. Examples are bus_req dropping without an acknowledge, rsp_valid falling without ready, or a cache-write burst of the wrong length. Each of these is visible in the very cycle it goes wrong.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA,
    ST_RESP,
    ST_FILL
  } lf_state_t;
endpackage

// File: rtl/lf_fill_buf.sv
module lf_fill_buf #(
  parameter int DW    = 64,
  parameter int BEATS = 4,
  localparam int SLW  = $clog2(BEATS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [SLW-1:0]      wr_slot,
  input  logic [DW-1:0]       wr_data,
  input  logic [SLW-1:0]      rd_slot,
  output logic [DW-1:0]       rd_data,
  output logic [DW*BEATS-1:0] line
);
  logic [DW-1:0] slot_q [BEATS];

  for (genvar k = 0; k < BEATS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                             slot_q[k] <= '0;
      else if (wr && wr_slot == SLW'(k))      slot_q[k] <= wr_data;
    end
    assign line[k*DW +: DW] = slot_q[k];
  end

  assign rd_data = slot_q[rd_slot];
endmodule

// File: rtl/lf_bytesel.sv
module lf_bytesel #(
  parameter int DW   = 64,
  localparam int BEW = DW / 8
) (
  input  logic [DW-1:0]  din,
  input  logic [BEW-1:0] be,
  output logic [DW-1:0]  dout
);
  for (genvar i = 0; i < BEW; i++) begin : g_byte
    assign dout[i*8 +: 8] = be[i] ? din[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int BEATS    = 4,
  parameter int FILL_CYC = 3,
  localparam int MAXC    = (BEATS > FILL_CYC) ? BEATS : FILL_CYC,
  localparam int CW      = $clog2(MAXC + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      is_line,
  input  logic      is_cacheable,
  input  logic      addrack,
  input  logic      rdack,
  input  logic      rsp_ready,
  output lf_state_t state,
  output logic      idle,
  output logic      bus_req,
  output logic      beat_we,
  output logic      rsp_valid,
  output logic      cw_wr,
  output logic      cw_commit
);
  localparam logic [CW-1:0] LAST_BEAT = CW'(BEATS - 1);
  localparam logic [CW-1:0] LAST_FILL = CW'(FILL_CYC - 1);

  lf_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (start) begin st_d = ST_REQ; cnt_d = '0; end
      ST_REQ:  if (addrack) st_d = ST_DATA;
      ST_DATA: if (rdack) begin
        if (!is_line || cnt_q == LAST_BEAT) st_d = ST_RESP;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_RESP: if (rsp_ready) begin
        cnt_d = '0;
        st_d  = (is_line && is_cacheable) ? ST_FILL : ST_IDLE;
      end
      ST_FILL: begin
        if (cnt_q == LAST_FILL) st_d = ST_IDLE;
        else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state     = st_q;
  assign idle      = (st_q == ST_IDLE);
  assign bus_req   = (st_q == ST_REQ);
  assign beat_we   = (st_q == ST_DATA) && rdack;
  assign rsp_valid = (st_q == ST_RESP);
  assign cw_wr     = (st_q == ST_FILL);
  assign cw_commit = (st_q == ST_FILL) && (cnt_q == LAST_FILL);
endmodule

// File: rtl/linefill_rd_master.sv
module linefill_rd_master
  import lf_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int BEATS    = 4,
  parameter int FILL_CYC = 3,
  localparam int BEW     = DW / 8,
  localparam int SLW     = $clog2(BEATS),
  localparam int WAW     = SLW + 1,
  localparam int DWOFF   = $clog2(BEW),
  localparam int LNOFF   = DWOFF + SLW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_valid,
  output logic                ld_ready,
  input  logic [AW-1:0]       ld_addr,
  input  logic                ld_line,
  input  logic                ld_cacheable,
  input  logic [BEW-1:0]      ld_be,
  output logic                bus_req,
  output logic                bus_rnw,
  output logic [AW-1:0]       bus_addr,
  output logic [BEW-1:0]      bus_be,
  output logic                bus_size_line,
  input  logic                bus_addrack,
  input  logic                bus_rdack,
  input  logic [DW-1:0]       bus_rddata,
  input  logic [WAW-1:0]      bus_rdwdaddr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DW-1:0]       rsp_data,
  output logic                busy,
  output logic                cw_wr,
  output logic                cw_commit,
  output logic [AW-1:0]       cw_addr,
  output logic [DW*BEATS-1:0] cw_line
);
  logic [AW-1:0]  addr_q;
  logic [BEW-1:0] be_q;
  logic           line_q, cach_q;
  logic           idle, start, beat_we;
  lf_state_t      state;
  logic [DW-1:0]  slot_data;

  assign start = ld_valid && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
      line_q <= 1'b0;
      cach_q <= 1'b0;
    end else if (start) begin
      addr_q <= ld_addr;
      be_q   <= ld_be;
      line_q <= ld_line;
      cach_q <= ld_cacheable;
    end
  end

  lf_ctrl #(.BEATS(BEATS), .FILL_CYC(FILL_CYC)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .is_line      (line_q),
    .is_cacheable (cach_q),
    .addrack      (bus_addrack),
    .rdack        (bus_rdack),
    .rsp_ready    (rsp_ready),
    .state        (state),
    .idle         (idle),
    .bus_req      (bus_req),
    .beat_we      (beat_we),
    .rsp_valid    (rsp_valid),
    .cw_wr        (cw_wr),
    .cw_commit    (cw_commit)
  );

  lf_fill_buf #(.DW(DW), .BEATS(BEATS)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (beat_we),
    .wr_slot (bus_rdwdaddr[WAW-1:1]),
    .wr_data (bus_rddata),
    .rd_slot (addr_q[DWOFF +: SLW]),
    .rd_data (slot_data),
    .line    (cw_line)
  );

  lf_bytesel #(.DW(DW)) u_sel (
    .din  (slot_data),
    .be   (be_q),
    .dout (rsp_data)
  );

  assign ld_ready      = idle;
  assign busy          = !idle;
  assign bus_rnw       = 1'b1;
  assign bus_size_line = line_q;
  assign bus_addr      = line_q ? {addr_q[AW-1:LNOFF], {LNOFF{1'b0}}} : addr_q;
  assign bus_be        = line_q ? {BEW{1'b1}} : be_q;
  assign cw_addr       = {addr_q[AW-1:LNOFF], {LNOFF{1'b0}}};
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int AW       = 32,
  parameter int BEW      = 8,
  parameter int FILL_CYC = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ld_ready,
  input logic           busy,
  input logic           bus_req,
  input logic           bus_rnw,
  input logic [AW-1:0]  bus_addr,
  input logic [BEW-1:0] bus_be,
  input logic           bus_size_line,
  input logic           bus_addrack,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [63:0]    rsp_data,
  input logic           cw_wr,
  input logic           cw_commit
);
  logic [7:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)     run_q <= '0;
    else if (cw_wr) run_q <= run_q + 8'd1;
    else            run_q <= '0;
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_addrack |=> bus_req && $stable(bus_addr) && $stable(bus_be) && $stable(bus_size_line));

  assert_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_rnw);

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_addrack |=> !bus_req);

  assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_fill_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cw_wr |-> (run_q < 8'(FILL_CYC)) && (cw_commit == (run_q == 8'(FILL_CYC - 1))));

  assert_fill_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cw_wr |-> !bus_req && !rsp_valid && !ld_ready);
endmodule

bind linefill_rd_master lf_checker #(.AW(AW), .BEW(BEW), .FILL_CYC(FILL_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ld_ready      (ld_ready),
  .busy          (busy),
  .bus_req       (bus_req),
  .bus_rnw       (bus_rnw),
  .bus_addr      (bus_addr),
  .bus_be        (bus_be),
  .bus_size_line (bus_size_line),
  .bus_addrack   (bus_addrack),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .cw_wr         (cw_wr),
  .cw_commit     (cw_commit)
);

// File: tb/linefill_rd_master_bench.sv
module linefill_rd_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         ld_valid = 0, ld_line = 0, ld_cacheable = 0;
  logic [31:0]  ld_addr = '0;
  logic [7:0]   ld_be = '0;
  logic         ld_ready, bus_req, bus_rnw, bus_size_line;
  logic [31:0]  bus_addr, cw_addr;
  logic [7:0]   bus_be;
  logic         bus_addrack = 0, bus_rdack = 0, rsp_ready = 0;
  logic [63:0]  bus_rddata = '0, rsp_data;
  logic [2:0]   bus_rdwdaddr = '0;
  logic         rsp_valid, busy, cw_wr, cw_commit;
  logic [255:0] cw_line;

  int checks = 0, errors = 0;

  linefill_rd_master u_linefill_rd_master (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_line(ld_line), .ld_cacheable(ld_cacheable), .ld_be(ld_be),
    .bus_req(bus_req), .bus_rnw(bus_rnw), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_size_line(bus_size_line), .bus_addrack(bus_addrack), .bus_rdack(bus_rdack),
    .bus_rddata(bus_rddata), .bus_rdwdaddr(bus_rdwdaddr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .busy(busy), .cw_wr(cw_wr),
    .cw_commit(cw_commit), .cw_addr(cw_addr), .cw_line(cw_line)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mask(input logic [63:0] d, input logic [7:0] be);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : 8'h00;
    return r;
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] a, input logic ln, input logic ca, input logic [7:0] be);
    ld_addr = a; ld_line = ln; ld_cacheable = ca; ld_be = be; ld_valid = 1;
    cyc();
    ld_valid = 0;
    chk("R4 bus_req after accept", bus_req, 1);
    chk("R7 ld_ready low when busy", {busy, ld_ready}, 2'b10);
    chk("R3 size flag", bus_size_line, ln);
    chk("R3 address", bus_addr, ln ? {a[31:5], 5'b0} : a);
    chk("R3 byte enables", bus_be, ln ? 8'hFF : be);
    chk("R2 read flag", bus_rnw, 1);
  endtask

  task automatic addr_ack(input int wait_cyc, input logic [31:0] exp_addr);
    for (int i = 0; i < wait_cyc; i++) begin
      cyc();
      chk("R2 request held", {bus_req, bus_addr}, {1'b1, exp_addr});
    end
    bus_addrack = 1;
    cyc();
    bus_addrack = 0;
    chk("R4 request drops after ack", bus_req, 0);
  endtask

  task automatic beat(input logic [1:0] slot, input logic [63:0] d);
    bus_rdack = 1; bus_rddata = d; bus_rdwdaddr = {slot, 1'b0};
    cyc();
    bus_rdack = 0; bus_rddata = '0;
  endtask

  task automatic take_rsp(input logic [63:0] exp, input int stall);
    chk("R10 rsp_valid after last beat", rsp_valid, 1);
    chk("R6 response bytes", rsp_data, exp);
    for (int i = 0; i < stall; i++) begin
      cyc();
      chk("R10 response held under back-pressure", {rsp_valid, rsp_data}, {1'b1, exp});
    end
    rsp_ready = 1;
    cyc();
    rsp_ready = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) cyc();
    chk("R1 outputs in reset", {bus_req, rsp_valid, cw_wr, busy, ld_ready}, 5'b00001);
    rst_n = 1;
    cyc();
    chk("R1 outputs after reset", {bus_req, rsp_valid, cw_wr, busy, ld_ready}, 5'b00001);
  endtask

  task automatic t_word_fast();
    logic [63:0] d = 64'h1122_3344_5566_7788;
    issue(32'h0000_1008, 0, 1, 8'h0F);
    addr_ack(0, 32'h0000_1008);
    beat(2'd1, d);
    take_rsp(mask(d, 8'h0F), 0);
    chk("R9 word read writes no cache", cw_wr, 0);
    chk("R7 idle after word", ld_ready, 1);
  endtask

  task automatic t_word_slow_ignore();
    logic [63:0] d = 64'hDEAD_BEEF_CAFE_F00D;
    issue(32'h0000_2010, 0, 0, 8'hA5);
    ld_valid = 1; ld_addr = 32'h0000_9990;
    addr_ack(2, 32'h0000_2010);
    beat(2'd2, d);
    ld_valid = 0;
    take_rsp(mask(d, 8'hA5), 2);
    cyc();
    chk("R7 load offered while busy ignored", {bus_req, ld_ready}, 2'b01);
  endtask

  task automatic t_line(input logic ca, input int stall);
    logic [63:0] b [4];
    for (int k = 0; k < 4; k++) b[k] = {8{8'(8'h10 * k + (ca ? 8'h3 : 8'h7))}};
    issue(32'h0000_4038, 1, ca, 8'hFF);
    addr_ack(1, 32'h0000_4020);
    beat(2'd2, b[2]);
    beat(2'd0, b[0]);
    beat(2'd3, b[3]);
    chk("R5 no response before fourth beat", rsp_valid, 0);
    beat(2'd1, b[1]);
    take_rsp(b[3], stall);
    if (ca) begin
      int n = 0;
      chk("R8 line order into cache", cw_line, {b[3], b[2], b[1], b[0]});
      chk("R8 line address", cw_addr, 32'h0000_4020);
      while (cw_wr && n < 10) begin
        chk("R8 no load accepted during transfer", ld_ready, 0);
        chk("R8 commit only on last cycle", cw_commit, n == 2);
        n++;
        cyc();
      end
      chk("R8 transfer length", n, 3);
    end else begin
      for (int i = 0; i < 4; i++) begin
        chk("R9 non-cacheable never written", cw_wr, 0);
        cyc();
      end
    end
    chk("R7 idle after line", ld_ready, 1);
  endtask

  initial begin
    t_reset();
    t_word_fast();
    t_word_slow_ignore();
    t_line(1, 0);
    t_line(0, 3);
    t_line(1, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule